// File: doc/BRIEF.md
# Multiplexed LED display scanner

This block drives an eight-position multiplexed seven-segment LED display from a latched BCD value. It lights one digit position at a time, from the most significant position (D8) down to the least significant (D1), and repeats the frame continuously. Each position owns a fixed slot of timebase ticks. The slot opens with a short dark gap that stops ghosting between neighbouring digits, and the digit's strobe is active for the rest of the slot. A shared 4-bit BCD bus carries the code of the position being scanned for the whole slot. The code is therefore valid for the length of the gap before that position's strobe turns on, so external logic can latch it on the strobe's leading edge.

Zeros to the left of the decimal point are suppressed on the segment lines, and this blanking stops when the counter feeding the display has overflowed. Overflow is shown on the decimal point of the most significant position. A display-test control lights every segment and decimal point. A display-off control darkens all strobe, segment and decimal-point lines and overrides display test. One polarity parameter adapts the drive lines to either display wiring.

Top module: `led_scan_top`

## Requirements
- R1: While reset is asserted and on the first edge after its release, every strobe, segment and decimal-point line is inactive and the BCD bus is 0. Scanning starts at the most significant position (index NUM_DIGITS-1, D8).
- R2: Each position holds for SLOT_TICKS ticks of `tick`, and positions follow in the order index 7 (D8) down to index 0 (D1), then wrap. The scan advances only on cycles where `tick` is high.
- R3: During the first GAP_TICKS ticks of a slot no strobe is active and the segment and decimal-point lines are inactive. For the remaining ticks, only the strobe of the current position is active (bit i of `digitEn` drives position i, bit 0 = D1).
- R4: Throughout each slot, `bcdOut` carries the current position's 4-bit code from `digitsIn[4*i+3:4*i]`, including the gap before the strobe. The BCD bus is not affected by blanking, display test or display off.
- R5: Segment bit 0 is a, through bit 6 is g. The codes 0-9 give the standard seven-segment shapes, and codes 10-15 light no segment.
- R6: A position with index above `dpPos` is blanked when its code and the codes of every higher position are all 0.
- R7: Positions at or below `dpPos` are never blanked, even when all of them are 0.
- R8: While `overflow` is high, no position is blanked.
- R9: The decimal-point line is active during the lit part of the `dpPos` slot. It is also active during the lit part of the D8 slot while `overflow` is high.
- R10: While `dispTest` is high, every lit slot shows all seven segments and the decimal point.
- R11: While `dispOff` is high, all strobe, segment and decimal-point lines are inactive, whatever `dispTest` is set to.
- R12: With ACTIVE_HIGH = 0, the strobe, segment and decimal-point lines are the bitwise inverse of the ACTIVE_HIGH = 1 lines, and `bcdOut` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable, one pulse per slot tick |
| digitsIn | input | 4*NUM_DIGITS | Latched BCD value, position i at bits 4i+3:4i |
| dpPos | input | clog2(NUM_DIGITS) | Index of the decimal-point position |
| overflow | input | 1 | Counter overflow flag |
| dispTest | input | 1 | Display test: all segments and points lit |
| dispOff | input | 1 | Display off: all drive lines inactive |
| digitEn | output | NUM_DIGITS | Digit strobes, bit 0 = D1 |
| segOut | output | 7 | Segments, bit 0 = a through bit 6 = g |
| dpOut | output | 1 | Decimal point |
| bcdOut | output | 4 | BCD code of the scanned position |

## Verification
A slot counter or position index that has drifted shows up as a strobe on the wrong line, or a strobe lit during the gap. This is visible on the first clock after the faulty tick, because the outputs are registered one cycle behind the scan state. A fault in the blanking chain or decimal-point selection changes `segOut` or `dpOut` only in the affected position's slot, so it can take up to one frame of NUM_DIGITS*SLOT_TICKS ticks to appear. The bench compares every output on every cycle against a behavioural model, which catches these faults within that frame.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

  // Position index width carried between control and datapath (up to 16 positions).
  localparam int SCAN_IDX_W = 4;

  typedef struct packed {
    logic [SCAN_IDX_W-1:0] digitIdx; // position being scanned
    logic                  lit;      // past the dark gap of the slot
  } scanStrobe_t;

  // Seven-segment shape, bit 0 = a .. bit 6 = g; codes above 9 stay dark.
  function automatic logic [6:0] segShape(input logic [3:0] code);
    logic [6:0] s;
    case (code)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/led_scan_ctrl.sv
module led_scan_ctrl
  import led_scan_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int SLOT_TICKS = 250,
  parameter int GAP_TICKS  = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  output scanStrobe_t strobe
);

  localparam int CNT_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(SLOT_TICKS - 1);
  localparam logic [CNT_W-1:0] GAP_END   = CNT_W'(GAP_TICKS);
  localparam logic [SCAN_IDX_W-1:0] TOP_IDX = SCAN_IDX_W'(NUM_DIGITS - 1);

  logic [CNT_W-1:0]      tickCnt;
  logic [SCAN_IDX_W-1:0] digitIdx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tickCnt  <= '0;
      digitIdx <= TOP_IDX;
    end else if (tick) begin
      if (tickCnt == SLOT_LAST) begin
        tickCnt  <= '0;
        digitIdx <= (digitIdx == '0) ? TOP_IDX : digitIdx - 1'b1;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.digitIdx = digitIdx;
    strobe.lit      = (tickCnt >= GAP_END);
  end

  // R2: scan state moves only on a tick
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(digitIdx) && $stable(tickCnt));

  // R3: a slot always opens dark
  a_r3_slot_opens_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (digitIdx != $past(digitIdx)) |-> (GAP_TICKS == 0) || !strobe.lit);

endmodule

// File: rtl/led_scan_dpath.sv
module led_scan_dpath
  import led_scan_pkg::*;
#(
  parameter int NUM_DIGITS  = 8,
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  scanStrobe_t                   strobe,
  input  logic [4*NUM_DIGITS-1:0]       digitsIn,
  input  logic [$clog2(NUM_DIGITS)-1:0] dpPos,
  input  logic                          overflow,
  input  logic                          dispTest,
  input  logic                          dispOff,
  output logic [NUM_DIGITS-1:0]         digitEn,
  output logic [6:0]                    segOut,
  output logic                          dpOut,
  output logic [3:0]                    bcdOut
);

  localparam int IDX_W = $clog2(NUM_DIGITS);
  localparam logic INV = !ACTIVE_HIGH;
  localparam logic [IDX_W-1:0] MSD_IDX = IDX_W'(NUM_DIGITS - 1);

  logic [NUM_DIGITS-1:0] zeroFrom;  // this and all higher positions are 0
  logic [NUM_DIGITS-1:0] blankPos;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_blank
    logic isZero;
    assign isZero = (digitsIn[4*i +: 4] == 4'd0);
    if (i == NUM_DIGITS - 1) begin : g_top
      assign zeroFrom[i] = isZero;
    end else begin : g_lower
      assign zeroFrom[i] = isZero && zeroFrom[i+1];
    end
    assign blankPos[i] = zeroFrom[i] && (IDX_W'(i) > dpPos) && !overflow;
  end

  logic [IDX_W-1:0]      curIdx;
  logic [3:0]            curCode;
  logic                  driveOn;
  logic [NUM_DIGITS-1:0] digAct;
  logic [6:0]            segAct;
  logic                  dpAct;

  always_comb begin
    curIdx  = IDX_W'(strobe.digitIdx);
    curCode = digitsIn[4*int'(curIdx) +: 4];
    driveOn = strobe.lit && !dispOff;
    digAct  = driveOn ? (NUM_DIGITS'(1) << curIdx) : '0;
    if (!driveOn)              segAct = 7'h00;
    else if (dispTest)         segAct = 7'h7F;
    else if (blankPos[curIdx]) segAct = 7'h00;
    else                       segAct = segShape(curCode);
    dpAct = driveOn && (dispTest || (curIdx == dpPos) ||
                        (overflow && (curIdx == MSD_IDX)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      digitEn <= {NUM_DIGITS{INV}};
      segOut  <= {7{INV}};
      dpOut   <= INV;
      bcdOut  <= 4'd0;
    end else begin
      digitEn <= digAct ^ {NUM_DIGITS{INV}};
      segOut  <= segAct ^ {7{INV}};
      dpOut   <= dpAct ^ INV;
      bcdOut  <= curCode;
    end
  end

  logic [NUM_DIGITS-1:0] digSeen;
  logic [6:0]            segSeen;
  logic                  dpSeen;
  assign digSeen = digitEn ^ {NUM_DIGITS{INV}};
  assign segSeen = segOut ^ {7{INV}};
  assign dpSeen  = dpOut ^ INV;

  // R2: the scan index never leaves the populated positions
  a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.digitIdx < SCAN_IDX_W'(NUM_DIGITS));

  // R3: at most one strobe at a time
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(digSeen));

  // R3: a dark gap from the control leaves every drive line dark
  a_r3_gap_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.lit |=> (digSeen == '0) && (segSeen == '0) && !dpSeen);

  // R11: display off darkens everything on the next edge
  a_r11_off_dark: assert property (@(posedge clk) disable iff (!rst_n)
    dispOff |=> (digSeen == '0) && (segSeen == '0) && !dpSeen);

  // R9: overflow lights the point during the most significant position
  a_r9_overflow_point: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !dispOff && strobe.lit && (strobe.digitIdx == SCAN_IDX_W'(NUM_DIGITS-1)))
      |=> dpSeen);

endmodule

// File: rtl/led_scan_top.sv
module led_scan_top
  import led_scan_pkg::*;
#(
  parameter int NUM_DIGITS  = 8,
  parameter int SLOT_TICKS  = 250,
  parameter int GAP_TICKS   = 6,
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic [4*NUM_DIGITS-1:0]       digitsIn,
  input  logic [$clog2(NUM_DIGITS)-1:0] dpPos,
  input  logic                          overflow,
  input  logic                          dispTest,
  input  logic                          dispOff,
  output logic [NUM_DIGITS-1:0]         digitEn,
  output logic [6:0]                    segOut,
  output logic                          dpOut,
  output logic [3:0]                    bcdOut
);

  scanStrobe_t strobe;

  led_scan_ctrl #(
    .NUM_DIGITS(NUM_DIGITS),
    .SLOT_TICKS(SLOT_TICKS),
    .GAP_TICKS (GAP_TICKS)
  ) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .strobe(strobe)
  );

  led_scan_dpath #(
    .NUM_DIGITS (NUM_DIGITS),
    .ACTIVE_HIGH(ACTIVE_HIGH)
  ) u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .digitsIn(digitsIn),
    .dpPos   (dpPos),
    .overflow(overflow),
    .dispTest(dispTest),
    .dispOff (dispOff),
    .digitEn (digitEn),
    .segOut  (segOut),
    .dpOut   (dpOut),
    .bcdOut  (bcdOut)
  );

endmodule

// File: tb/sim_led_scan_top.sv
module sim_led_scan_top;

  localparam int N    = 8;
  localparam int SLOT = 8;
  localparam int GAP  = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic [31:0]  digitsIn = 32'h0;
  logic [2:0]   dpPos = 3'd0;
  logic         overflow = 1'b0, dispTest = 1'b0, dispOff = 1'b0;
  logic         sparse = 1'b0;

  logic [7:0] digitEn, digitEnN;
  logic [6:0] segOut, segOutN;
  logic       dpOut, dpOutN;
  logic [3:0] bcdOut, bcdOutN;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit started = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  led_scan_top #(.NUM_DIGITS(N), .SLOT_TICKS(SLOT), .GAP_TICKS(GAP), .ACTIVE_HIGH(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .digitsIn(digitsIn), .dpPos(dpPos),
    .overflow(overflow), .dispTest(dispTest), .dispOff(dispOff),
    .digitEn(digitEn), .segOut(segOut), .dpOut(dpOut), .bcdOut(bcdOut));

  led_scan_top #(.NUM_DIGITS(N), .SLOT_TICKS(SLOT), .GAP_TICKS(GAP), .ACTIVE_HIGH(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .digitsIn(digitsIn), .dpPos(dpPos),
    .overflow(overflow), .dispTest(dispTest), .dispOff(dispOff),
    .digitEn(digitEnN), .segOut(segOutN), .dpOut(dpOutN), .bcdOut(bcdOutN));

  // ---------------- behavioural reference ----------------
  int         mIdx = N - 1;
  int         mCnt = 0;
  int         expIdx = N - 1;
  bit         expLit = 0;
  logic [7:0] expDig = 8'h00;
  logic [6:0] expSeg = 7'h00;
  logic       expDp = 1'b0;
  logic [3:0] expBcd = 4'h0;

  function automatic logic [6:0] shape(input logic [3:0] v);
    case (v)
      0: return 7'b0111111;  1: return 7'b0000110;
      2: return 7'b1011011;  3: return 7'b1001111;
      4: return 7'b1100110;  5: return 7'b1101101;
      6: return 7'b1111101;  7: return 7'b0000111;
      8: return 7'b1111111;  9: return 7'b1101111;
      default: return 7'b0000000;
    endcase
  endfunction

  function automatic bit suppressed(input int idx);
    if (overflow || idx <= int'(dpPos)) return 0;
    for (int j = idx; j < N; j++)
      if (digitsIn[4*j +: 4] != 4'd0) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mIdx = N - 1; mCnt = 0;
      expIdx = N - 1; expLit = 0;
      expDig = 0; expSeg = 0; expDp = 0; expBcd = 0;
    end else begin
      bit on;
      expIdx = mIdx;
      expLit = (mCnt >= GAP);
      on     = expLit && !dispOff;
      expBcd = digitsIn[4*mIdx +: 4];
      expDig = on ? (8'h01 << mIdx) : 8'h00;
      if (!on) expSeg = 0;
      else if (dispTest) expSeg = 7'h7F;
      else if (suppressed(mIdx)) expSeg = 0;
      else expSeg = shape(expBcd);
      expDp = on && (dispTest || mIdx == int'(dpPos) || (overflow && mIdx == N - 1));
      if (tick) begin
        if (mCnt == SLOT - 1) begin
          mCnt = 0;
          mIdx = (mIdx == 0) ? N - 1 : mIdx - 1;
        end else mCnt = mCnt + 1;
      end
    end
    cycles++;
    if (!finished) started = 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, expv);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (started && rst_n && !finished) begin
      check("R3 strobes", {24'h0, digitEn}, {24'h0, expDig});
      check("R5 segments", {25'h0, segOut}, {25'h0, expSeg});
      check("R9 point", {31'h0, dpOut}, {31'h0, expDp});
      check("R4 bcd", {28'h0, bcdOut}, {28'h0, expBcd});
      check("R12 inverted lines", {16'h0, digitEnN, segOutN, dpOutN},
            {16'h0, ~digitEn, ~segOut, ~dpOut});
      check("R12 bcd same", {28'h0, bcdOutN}, {28'h0, bcdOut});
    end
  end

  // tick generator: every cycle, or one in three when sparse
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph == 2) ? 0 : ph + 1;
      tick = sparse ? (ph == 0) : 1'b1;
    end
  end

  task automatic waitLit(input int idx);
    do @(negedge clk); while (!(expLit && expIdx == idx));
  endtask

  task automatic waitGap(input int idx);
    do @(negedge clk); while (!(!expLit && expIdx == idx));
  endtask

  // watchdog
  initial begin
    wait (cycles > 60000);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 strobes in reset", {24'h0, digitEn}, 32'h0);
    check("R1 segments in reset", {25'h0, segOut}, 32'h0);
    check("R1 point in reset", {31'h0, dpOut}, 32'h0);
    check("R1 bcd in reset", {28'h0, bcdOut}, 32'h0);
    digitsIn = 32'h9A3F5210;  // D8..D1 = 9 A 3 F 5 2 1 0
    dpPos = 3'd7;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1/R4: first slot is D8, dark, with its code already on the bus
    check("R1 dark after release", {24'h0, digitEn}, 32'h0);
    check("R4 bcd leads strobe", {28'h0, bcdOut}, 32'h9);
    waitLit(7);
    check("R2 D8 first", {24'h0, digitEn}, 32'h80);
    waitLit(6);
    check("R2 then D7", {24'h0, digitEn}, 32'h40);
    check("R5 code 10 dark", {25'h0, segOut}, 32'h0);
    waitLit(4);
    check("R5 code 15 dark", {25'h0, segOut}, 32'h0);
    waitLit(1);
    check("R5 shape 1", {25'h0, segOut}, 32'h06);
    waitGap(0);
    check("R3 gap dark", {24'h0, digitEn}, 32'h0);
    check("R4 bcd in gap", {28'h0, bcdOut}, 32'h0);

    // R6: leading zeros blanked above the point, bus unaffected
    digitsIn = 32'h00000120; dpPos = 3'd0;
    waitLit(7);
    check("R6 leading zero blank", {25'h0, segOut}, 32'h0);
    check("R4 bcd ignores blanking", {28'h0, bcdOut}, 32'h0);
    check("R6 strobe still runs", {24'h0, digitEn}, 32'h80);
    waitLit(2);
    check("R6 first nonzero shown", {25'h0, segOut}, 32'h06);
    waitLit(0);
    check("R7 zero at point shown", {25'h0, segOut}, 32'h3F);
    check("R9 point at dpPos", {31'h0, dpOut}, 32'h1);

    // R7: all-zero value with point at D4
    digitsIn = 32'h0; dpPos = 3'd3;
    waitLit(4);
    check("R6 zero above point blank", {25'h0, segOut}, 32'h0);
    waitLit(3);
    check("R7 zero at point shown", {25'h0, segOut}, 32'h3F);
    waitLit(1);
    check("R7 zero right of point", {25'h0, segOut}, 32'h3F);

    // R8/R9: overflow stops blanking and lights the D8 point
    overflow = 1'b1;
    waitLit(7);
    check("R8 no blank on overflow", {25'h0, segOut}, 32'h3F);
    check("R9 overflow point D8", {31'h0, dpOut}, 32'h1);
    waitLit(5);
    check("R9 no point elsewhere", {31'h0, dpOut}, 32'h0);
    waitLit(3);
    check("R9 point at dpPos", {31'h0, dpOut}, 32'h1);
    overflow = 1'b0;

    // R2: sparse ticks stretch the scan
    sparse = 1'b1;
    digitsIn = 32'h87654321; dpPos = 3'd0;
    waitLit(5);
    check("R2 sparse scan", {24'h0, digitEn}, 32'h20);
    check("R5 shape 6", {25'h0, segOut}, 32'h7D);
    waitLit(4);
    check("R5 shape 5", {25'h0, segOut}, 32'h6D);
    sparse = 1'b0;

    // R10: display test
    dispTest = 1'b1;
    waitLit(4);
    check("R10 all segments", {25'h0, segOut}, 32'h7F);
    check("R10 all points", {31'h0, dpOut}, 32'h1);
    check("R4 bcd during test", {28'h0, bcdOut}, 32'h5);

    // R11: display off overrides test
    dispOff = 1'b1;
    waitLit(2);
    check("R11 strobes off", {24'h0, digitEn}, 32'h0);
    check("R11 segments off", {25'h0, segOut}, 32'h0);
    check("R11 point off", {31'h0, dpOut}, 32'h0);
    check("R4 bcd during off", {28'h0, bcdOut}, 32'h3);
    dispOff = 1'b0; dispTest = 1'b0;
    waitLit(1);
    check("R11 display back", {24'h0, digitEn}, 32'h02);

    // one full extra frame of continuous comparison
    waitLit(7);
    waitLit(0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule